// File: doc/BRIEF.md
# ECC-Protected SRAM Bank Controller

This block connects a 32-bit system bus to a set of on-chip SRAM banks. Each bank stores 32-bit data words and, next to every word, a 7-bit single-error-correct / double-error-detect checksum. A full-word write stores the data together with a freshly computed checksum. A byte or halfword write to a protected bank reads the old word, corrects it, merges the new byte lanes, recomputes the checksum and writes both back. That read-modify-write holds the bus-ready signal low for two extra cycles. Reads are checked. A single flipped data bit is repaired on its way out, and an uncorrectable word is returned as stored and latched in a sticky per-bank flag.

Two static configuration bits apply to each bank. The disable bit turns protection off for that bank. Writes then go straight to the data lanes in a single cycle and leave the checksum untouched, and reads return the stored data unchecked. The diagnostic map bit redirects full-word accesses to that bank's checksum array, so test software can read a checksum or plant a corrupted one. Error handling can then be exercised with no other test hardware. Map mode refuses sub-word accesses with an error response. It works whether or not the bank's disable bit is set.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: After reset `ready` is 1, `resp_valid` and `resp_err` are 0 and every bit of `ue_flag` is 0.
- R2: The checksum of a data word is defined column by column. The 7-bit values with exactly three ones, taken in ascending numeric order, are the columns of data bits 0 to 31. Checksum bit j is the XOR of the data bits whose column has bit j set. A full-word write (`be` = 4'hF) to a protected bank stores this value.
- R3: A request is accepted on a rising edge where `req` and `ready` are both 1. A full-word access, and any access to a disabled bank, is answered with `resp_valid` = 1 in the cycle that follows, and `ready` stays 1. For reads that response cycle carries `rdata`. For writes `rdata` is 0.
- R4: A write with `be` not 4'hF to a protected bank in normal mode holds `ready` at 0 for the two cycles after acceptance and gives `resp_valid` in the third cycle. The stored word then holds the new bytes in the lanes where `be` is 1 (lane n = bits 8n+7:8n) and the corrected old bytes elsewhere, with a checksum matching that word.
- R5: A protected read whose syndrome (stored checksum XOR recomputed checksum) equals the column of data bit i returns the stored word with bit i inverted, and leaves `ue_flag` unchanged.
- R6: A protected read whose syndrome has exactly one bit set returns the stored data unchanged and does not set `ue_flag`.
- R7: Any other nonzero syndrome is uncorrectable. The read returns the stored data unchanged, and the bit of `ue_flag` for that bank goes to 1 one cycle after the response. The same happens when the old-word read of a sub-word write is uncorrectable. The bit then stays 1 until reset, and the other banks' bits are unaffected.
- R8: With `ecc_dis` set for a bank, writes store only the byte lanes selected by `be` and leave the checksum as it was, and reads return the stored data with no check and no flag.
- R9: With `map_en` set for a bank, a full-word read returns that word's checksum in `rdata[6:0]`, with `rdata[31:7]` = 0.
- R10: With `map_en` set, a full-word write replaces the checksum with `wdata[6:0]`. It ignores `wdata[31:7]` and leaves the data word unchanged.
- R11: With `map_en` set, an access with `be` not 4'hF is answered in the next cycle with `resp_valid` = 1 and `resp_err` = 1, and it changes neither the data nor the checksum. `resp_err` is 0 for every other access.
- R12: Map-mode reads and writes behave as in R9 and R10 whether or not `ecc_dis` is set for that bank.
- R13: Word address `addr` selects bank `addr[8:6]` and word `addr[5:0]` within it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ecc_dis | input | 8 | Per-bank protection disable |
| map_en | input | 8 | Per-bank checksum diagnostic map enable |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 9 | Word address: bank in the upper 3 bits |
| be | input | 4 | Byte-lane enables |
| wdata | input | 32 | Write data |
| ready | output | 1 | Controller can accept a request |
| resp_valid | output | 1 | Response cycle |
| resp_err | output | 1 | Access refused |
| rdata | output | 32 | Read data, valid with `resp_valid` |
| ue_flag | output | 8 | Sticky uncorrectable-error status per bank |

## Verification
The assertions assume that `req` is raised only while `ready` is 1 and that `ecc_dis` and `map_en` do not change while an access is in flight. They also assume that `be` is never zero. The bench changes the configuration bits only in idle cycles, and it always waits for the response and one idle cycle before the next request. Corrupted words are produced only through map-mode checksum writes. Words that were never written are never read, so every expected value comes from stored contents that the bench model knows.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DW = 32;
  localparam int CW = 7;
  localparam int NLANE = DW / 8;

  typedef enum logic [1:0] {S_IDLE, S_MERGE, S_WB} ctl_state_t;
  typedef enum logic [1:0] {K_NONE, K_RAW, K_ECC, K_MAP} rd_kind_t;

  // Column table: weight-3 codes of CW bits in ascending order.
  function automatic logic [DW*CW-1:0] build_tab();
    logic [DW*CW-1:0] t;
    logic [CW-1:0]    vv;
    int               n;
    int               w;
    t = '0;
    n = 0;
    for (int v = 1; v < (1 << CW); v++) begin
      vv = v[CW-1:0];
      w  = 0;
      for (int b = 0; b < CW; b++) w += int'(vv[b]);
      if (w == 3 && n < DW) begin
        t[n*CW +: CW] = vv;
        n++;
      end
    end
    return t;
  endfunction

  localparam logic [DW*CW-1:0] HTAB = build_tab();
endpackage

// File: rtl/ecc_hsiao_enc.sv
module ecc_hsiao_enc
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] d,
  output logic [CW-1:0] c
);
  always_comb begin
    c = '0;
    for (int i = 0; i < DW; i++) begin
      if (d[i]) c = c ^ HTAB[i*CW +: CW];
    end
  end
endmodule

// File: rtl/ecc_hsiao_dec.sv
module ecc_hsiao_dec
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] d,
  input  logic [CW-1:0] c,
  output logic [DW-1:0] dout,
  output logic          ue
);
  logic [CW-1:0] recomp;
  logic [CW-1:0] syn;
  logic [DW-1:0] flip;
  logic          chk_only;

  ecc_hsiao_enc u_enc (.d(d), .c(recomp));

  assign syn = c ^ recomp;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      flip[i] = (syn == HTAB[i*CW +: CW]);
    end
  end

  assign chk_only = (syn != '0) && ((syn & (syn - CW'(1))) == '0);
  assign ue       = (syn != '0) && !chk_only && (flip == '0);
  assign dout     = d ^ flip;

  // R5
  always_comb begin
    one_flip_chk: assert ($onehot0(flip));
  end
endmodule

// File: rtl/ecc_bank_mem.sv
module ecc_bank_mem
  import ecc_sram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_d,
  input  logic [NLANE-1:0] be,
  input  logic             we_c,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    wd,
  input  logic [CW-1:0]    wc,
  output logic [DW-1:0]    rd,
  output logic [CW-1:0]    rc
);
  logic [DW-1:0] mem_d [DEPTH];
  logic [CW-1:0] mem_c [DEPTH];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we_d && be[l]) mem_d[idx][8*l +: 8] <= wd[8*l +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (we_c) mem_c[idx] <= wc;
  end

  assign rd = mem_d[idx];
  assign rc = mem_c[idx];
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int BANK_WORDS = 64,
  localparam int BW = $clog2(NBANK),
  localparam int IW = $clog2(BANK_WORDS),
  localparam int AW = BW + IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] ecc_dis,
  input  logic [NBANK-1:0] map_en,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [NLANE-1:0] be,
  input  logic [DW-1:0]    wdata,
  output logic             ready,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [DW-1:0]    rdata,
  output logic [NBANK-1:0] ue_flag
);
  localparam logic [NLANE-1:0] FULL = '1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_ff;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s = rst_ff[1];

  // registers and next-state values
  ctl_state_t       st_q, st_n;
  rd_kind_t         kind_q, kind_n;
  logic             rv_q, rv_n, re_q, re_n;
  logic [BW-1:0]    bank_q, bank_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic [NLANE-1:0] be_q, be_n;
  logic [DW-1:0]    wdat_q, wdat_n;
  logic [DW-1:0]    raw_d_q, raw_d_n;
  logic [CW-1:0]    raw_c_q, raw_c_n;
  logic [DW-1:0]    mrg_d_q, mrg_d_n;
  logic [CW-1:0]    mrg_c_q, mrg_c_n;
  logic [NBANK-1:0] ue_q, ue_n;

  // decode of the incoming request
  logic          acc, a_map, a_dis, a_full;
  logic [BW-1:0] a_bank;
  logic [IW-1:0] a_idx;

  assign ready  = (st_q == S_IDLE);
  assign acc    = req && ready;
  assign a_bank = addr[AW-1:IW];
  assign a_idx  = addr[IW-1:0];
  assign a_map  = map_en[a_bank];
  assign a_dis  = ecc_dis[a_bank];
  assign a_full = (be == FULL);

  // shared encoder: request data, or merged word during MERGE
  logic [DW-1:0] enc_in, dec_out, merged;
  logic [CW-1:0] enc_out;
  logic          dec_ue;

  assign enc_in = (st_q == S_MERGE) ? merged : wdata;
  ecc_hsiao_enc u_enc (.d(enc_in), .c(enc_out));
  ecc_hsiao_dec u_dec (.d(raw_d_q), .c(raw_c_q), .dout(dec_out), .ue(dec_ue));

  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      merged[8*l +: 8] = be_q[l] ? wdat_q[8*l +: 8] : dec_out[8*l +: 8];
    end
  end

  // memory port control
  logic             m_we_d, m_we_c;
  logic [BW-1:0]    m_bank;
  logic [IW-1:0]    m_idx;
  logic [NLANE-1:0] m_be;
  logic [DW-1:0]    m_wd;
  logic [CW-1:0]    m_wc;

  always_comb begin
    m_bank = a_bank;
    m_idx  = a_idx;
    m_be   = be;
    m_wd   = wdata;
    m_wc   = enc_out;
    m_we_d = 1'b0;
    m_we_c = 1'b0;
    if (st_q == S_WB) begin
      m_bank = bank_q;
      m_idx  = idx_q;
      m_be   = FULL;
      m_wd   = mrg_d_q;
      m_wc   = mrg_c_q;
      m_we_d = 1'b1;
      m_we_c = 1'b1;
    end else if (acc && we) begin
      if (a_map) begin
        m_wc   = wdata[CW-1:0];
        m_we_c = a_full;
      end else if (a_dis) begin
        m_we_d = 1'b1;
      end else if (a_full) begin
        m_we_d = 1'b1;
        m_we_c = 1'b1;
      end
    end
  end

  logic [DW-1:0] bank_rd [NBANK];
  logic [CW-1:0] bank_rc [NBANK];
  logic          ue_set;

  assign ue_set = dec_ue && ((rv_q && kind_q == K_ECC) || st_q == S_MERGE);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic sel;
    assign sel = (m_bank == BW'(g));
    ecc_bank_mem #(.DEPTH(BANK_WORDS)) u_mem (
      .clk  (clk),
      .we_d (m_we_d && sel),
      .be   (m_be),
      .we_c (m_we_c && sel),
      .idx  (m_idx),
      .wd   (m_wd),
      .wc   (m_wc),
      .rd   (bank_rd[g]),
      .rc   (bank_rc[g])
    );
    assign ue_n[g] = ue_q[g] | (ue_set && bank_q == BW'(g));

    // R7
    ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
      !$fell(ue_q[g]));
  end

  // next-state logic
  always_comb begin
    st_n    = st_q;
    kind_n  = K_NONE;
    rv_n    = 1'b0;
    re_n    = 1'b0;
    bank_n  = bank_q;
    idx_n   = idx_q;
    be_n    = be_q;
    wdat_n  = wdat_q;
    raw_d_n = raw_d_q;
    raw_c_n = raw_c_q;
    mrg_d_n = mrg_d_q;
    mrg_c_n = mrg_c_q;
    case (st_q)
      S_IDLE: begin
        if (acc) begin
          bank_n  = a_bank;
          idx_n   = a_idx;
          be_n    = be;
          wdat_n  = wdata;
          raw_d_n = bank_rd[a_bank];
          raw_c_n = bank_rc[a_bank];
          if (a_map && !a_full) begin
            rv_n = 1'b1;
            re_n = 1'b1;
          end else if (we && !a_map && !a_dis && !a_full) begin
            st_n = S_MERGE;
          end else begin
            rv_n = 1'b1;
            if (!we) kind_n = a_map ? K_MAP : (a_dis ? K_RAW : K_ECC);
          end
        end
      end
      S_MERGE: begin
        mrg_d_n = merged;
        mrg_c_n = enc_out;
        st_n    = S_WB;
      end
      S_WB: begin
        rv_n = 1'b1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= S_IDLE;
      kind_q <= K_NONE;
      rv_q   <= 1'b0;
      re_q   <= 1'b0;
      ue_q   <= '0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      rv_q   <= rv_n;
      re_q   <= re_n;
      ue_q   <= ue_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bank_q  <= '0;
      idx_q   <= '0;
      be_q    <= '0;
      wdat_q  <= '0;
      raw_d_q <= '0;
      raw_c_q <= '0;
      mrg_d_q <= '0;
      mrg_c_q <= '0;
    end else begin
      bank_q  <= bank_n;
      idx_q   <= idx_n;
      be_q    <= be_n;
      wdat_q  <= wdat_n;
      raw_d_q <= raw_d_n;
      raw_c_q <= raw_c_n;
      mrg_d_q <= mrg_d_n;
      mrg_c_q <= mrg_c_n;
    end
  end

  // outputs
  always_comb begin
    case (kind_q)
      K_MAP:   rdata = {{(DW-CW){1'b0}}, raw_c_q};
      K_ECC:   rdata = dec_out;
      K_RAW:   rdata = raw_d_q;
      default: rdata = '0;
    endcase
  end

  assign resp_valid = rv_q;
  assign resp_err   = re_q;
  assign ue_flag    = ue_q;

  // R3
  word_resp_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && a_full) |=> (resp_valid && ready));

  // R3
  resp_ready_chk: assert property (@(posedge clk) disable iff (!rst_s)
    resp_valid |-> ready);

  // R4
  rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && we && !a_map && !a_dis && !a_full) |=> (!ready && !resp_valid));

  // R11
  map_refuse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && a_map && !a_full) |=> (resp_valid && resp_err));

  // R11
  err_valid_chk: assert property (@(posedge clk) disable iff (!rst_s)
    resp_err |-> resp_valid);
endmodule

// File: tb/ecc_sram_ctrl_tb.sv
module ecc_sram_ctrl_tb;
  logic        clk, rst_n, req, we;
  logic [7:0]  dis_v, map_v;
  logic [8:0]  addr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic        ready, resp_valid, resp_err;
  logic [31:0] rdata;
  logic [7:0]  ue_flag;

  ecc_sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ecc_dis(dis_v), .map_en(map_v),
    .req(req), .we(we), .addr(addr), .be(be), .wdata(wdata),
    .ready(ready), .resp_valid(resp_valid), .resp_err(resp_err),
    .rdata(rdata), .ue_flag(ue_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] mdat [512];
  logic [6:0]  mchk [512];
  logic [7:0]  ue_m;

  function automatic logic [6:0] m_col(input int i);
    int n = 0;
    for (int v = 0; v < 128; v++) begin
      if ($countones(v[6:0]) == 3) begin
        if (n == i) return v[6:0];
        n++;
      end
    end
    return 7'h0;
  endfunction

  function automatic logic [6:0] m_enc(input logic [31:0] d);
    logic [6:0] c = 7'h0;
    for (int i = 0; i < 32; i++) if (d[i]) c ^= m_col(i);
    return c;
  endfunction

  task automatic m_decode(input logic [31:0] d, input logic [6:0] c,
                          output logic [31:0] o, output bit u);
    logic [6:0] s;
    s = c ^ m_enc(d);
    o = d;
    u = 1'b0;
    if (s != 7'h0 && $countones(s) != 1) begin
      u = 1'b1;
      for (int i = 0; i < 32; i++) begin
        if (s == m_col(i)) begin
          o = d ^ (32'h1 << i);
          u = 1'b0;
        end
      end
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic xact(input logic w, input logic [8:0] a, input logic [3:0] b,
                      input logic [31:0] wd, input string tag);
    int          bk, lat;
    bit          mp, ds, full, u, eerr;
    logic [31:0] erd, o, m;
    bk   = int'(a[8:6]);
    mp   = map_v[bk];
    ds   = dis_v[bk];
    full = (b == 4'hF);
    lat  = (w && !mp && !ds && !full) ? 3 : 1;
    eerr = mp && !full;
    erd  = 32'h0;
    if (eerr) begin
    end else if (mp) begin
      if (w) mchk[a] = wd[6:0];
      else   erd = {25'h0, mchk[a]};
    end else if (w && ds) begin
      for (int l = 0; l < 4; l++) if (b[l]) mdat[a][8*l +: 8] = wd[8*l +: 8];
    end else if (w && full) begin
      mdat[a] = wd;
      mchk[a] = m_enc(wd);
    end else if (w) begin
      m_decode(mdat[a], mchk[a], o, u);
      m = o;
      for (int l = 0; l < 4; l++) if (b[l]) m[8*l +: 8] = wd[8*l +: 8];
      mdat[a] = m;
      mchk[a] = m_enc(m);
      if (u) ue_m[bk] = 1'b1;
    end else if (ds) begin
      erd = mdat[a];
    end else begin
      m_decode(mdat[a], mchk[a], o, u);
      erd = o;
      if (u) ue_m[bk] = 1'b1;
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      chk(tag, "resp_valid", 32'(resp_valid), 32'(k == lat));
      chk(tag, "ready", 32'(ready), 32'(k == lat));
      if (k == lat) begin
        chk(tag, "resp_err", 32'(resp_err), 32'(eerr));
        chk(tag, "rdata", rdata, erd);
      end
    end
    @(negedge clk);
    chk(tag, "idle resp_valid", 32'(resp_valid), 32'h0);
    chk(tag, "idle ready", 32'(ready), 32'h1);
    chk(tag, "ue_flag", 32'(ue_flag), 32'(ue_m));
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    xact(1'b0, a, 4'hF, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; be = 4'hF;
    wdata = '0; dis_v = '0; map_v = '0; ue_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready", 32'(ready), 32'h1);
    chk("R1", "resp_valid", 32'(resp_valid), 32'h0);
    chk("R1", "resp_err", 32'(resp_err), 32'h0);
    chk("R1", "ue_flag", 32'(ue_flag), 32'h0);

    // R2 R3 R13 word writes and reads over several banks
    xact(1'b1, 9'h000, 4'hF, 32'hA5A5_1234, "R2");
    xact(1'b1, 9'h0C5, 4'hF, 32'h0F0F_F0F0, "R2");
    xact(1'b1, 9'h1FF, 4'hF, 32'hFFFF_FFFF, "R2");
    xact(1'b1, 9'h005, 4'hF, 32'h1111_2222, "R13");
    xact(1'b1, 9'h045, 4'hF, 32'h3333_4444, "R13");
    xact(1'b1, 9'h081, 4'hF, 32'hDEAD_BEEF, "R3");
    rd(9'h000, "R3");
    rd(9'h0C5, "R3");
    rd(9'h1FF, "R3");
    rd(9'h005, "R13");
    rd(9'h045, "R13");

    // R9 map read exposes stored checksum
    map_v = 8'h09;
    rd(9'h0C5, "R9");
    rd(9'h000, "R9");
    map_v = 8'h00;

    // R4 byte and halfword read-modify-write
    xact(1'b1, 9'h0C5, 4'b0100, 32'h00AB_0000, "R4");
    rd(9'h0C5, "R4");
    xact(1'b1, 9'h1FF, 4'b0011, 32'h0000_5A5A, "R4");
    rd(9'h1FF, "R4");

    // R6 single checksum-bit error
    map_v = 8'h01;
    xact(1'b1, 9'h000, 4'hF, {25'h0, mchk[9'h000] ^ 7'h01}, "R6");
    map_v = 8'h00;
    rd(9'h000, "R6");

    // R5 single data-bit error is corrected
    map_v = 8'h08;
    xact(1'b1, 9'h0C5, 4'hF, {25'h0, mchk[9'h0C5] ^ m_col(5)}, "R5");
    map_v = 8'h00;
    rd(9'h0C5, "R5");

    // R7 double error: raw data, sticky flag of bank 7 only
    map_v = 8'h80;
    xact(1'b1, 9'h1FF, 4'hF, {25'h0, mchk[9'h1FF] ^ m_col(2) ^ m_col(9)}, "R7");
    map_v = 8'h00;
    rd(9'h1FF, "R7");
    rd(9'h005, "R7");

    // R11 map-mode sub-word access refused, nothing changed
    map_v = 8'h08;
    xact(1'b1, 9'h0C5, 4'b0001, 32'h0000_00FF, "R11");
    xact(1'b0, 9'h0C5, 4'b0011, 32'h0, "R11");
    rd(9'h0C5, "R11");
    map_v = 8'h00;
    rd(9'h0C5, "R11");

    // R4 sub-word write over a correctable word rewrites it clean
    xact(1'b1, 9'h0C5, 4'b0001, 32'h0000_0077, "R4");
    rd(9'h0C5, "R4");

    // R10 map write ignores upper bits and leaves data
    map_v = 8'h08;
    xact(1'b1, 9'h0C5, 4'hF, {25'h1ABCDEF, mchk[9'h0C5] ^ 7'h40}, "R10");
    rd(9'h0C5, "R10");
    map_v = 8'h00;
    rd(9'h0C5, "R10");

    // R8 R12 disabled bank 2
    dis_v = 8'h04;
    xact(1'b1, 9'h081, 4'hF, 32'h0123_4567, "R8");
    map_v = 8'h04;
    rd(9'h081, "R12");
    xact(1'b1, 9'h082, 4'hF, 32'h0000_0055, "R12");
    rd(9'h082, "R12");
    map_v = 8'h00;
    xact(1'b1, 9'h081, 4'b1000, 32'hCC00_0000, "R8");
    rd(9'h081, "R8");
    dis_v = 8'h00;
    rd(9'h081, "R8");
    rd(9'h1FF, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule